// File: doc/BRIEF.md
# Per-Pin GPIO Interrupt Detector

This block watches the synchronised input pins of a small GPIO port and turns selected activity on each pin into an interrupt. Every pin has its own trigger setting. It can fire on a rising transition, a falling transition, any transition, a high level or a low level. Three single-bit-per-pin configuration registers select the setting: one picks level or edge, one selects any-transition and one selects the polarity.

Edge events are held in a sticky status bit until software writes a one to that bit in the acknowledge register. Level status is not stored. It follows the pin, so an acknowledge cannot remove it while the condition still holds. A per-pin enable register gates the raw status into a masked status, and the single interrupt line is the OR of the masked bits. Software reaches the block through a simple register port. Writes land on a clock edge and reads are combinational.

Top module: `gpio_irq_unit`

## Requirements
- R1: After reset every configuration register (level-select, any-edge, polarity, enable) reads 0, raw and masked status read 0 and `irq_out` is low.
- R2: The configuration registers are written and read back at these offsets: level-select 0x404, any-edge 0x408, polarity 0x40C, enable 0x410. Bit i of each register belongs to pin i.
- R3: With level-select=0, any-edge=0 and polarity=1, a 0-to-1 change of a pin sets its raw status bit on the next clock edge. A 1-to-0 change does not set it.
- R4: With level-select=0, any-edge=0 and polarity=0, only a 1-to-0 change sets the bit.
- R5: With level-select=0 and any-edge=1, either change sets the bit, whatever the polarity bit holds.
- R6: With level-select=1, the raw status bit equals the pin when polarity=1 and its inverse when polarity=0. It follows the pin with no clock delay.
- R7: An edge status bit stays set until a write to 0x41C has a 1 in that bit position. Bits written as 0 leave their status unchanged.
- R8: A write of 1 to 0x41C has no effect on a level-sensitive pin whose condition still holds.
- R9: An edge that is detected in the same cycle as an acknowledge of that bit leaves the bit set.
- R10: Raw status reads at 0x414. Masked status at 0x418 reads raw AND enable.
- R11: `irq_out` is high exactly when any masked status bit is 1.
- R12: Changing any configuration register while the pins are steady sets no edge status. The first pin sample after reset is never taken as an edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| pin_in | input | NPINS | Synchronised pin values |
| reg_wr | input | 1 | Write strobe for the register port |
| reg_addr | input | ADDR_W | Byte offset of the access |
| reg_wdata | input | NPINS | Write data, one bit per pin |
| reg_rdata | output | NPINS | Combinational read data at `reg_addr` |
| irq_out | output | 1 | Combined interrupt request |

## Verification
The main sweep puts each of the eight pins through all six trigger settings: rise, fall, any-edge with both polarity values, high and low. Each pin is driven through the sequence 0, 1, 0, 1 while its neighbours stay quiet. Raw status, masked status and `irq_out` are compared after every step. This separates edges that latch from levels that follow the pin. It shows that any-edge overrides polarity, and that only the configured pin responds. Directed cases cover a partial acknowledge, an acknowledge racing a new edge, an acknowledge against a level that still holds, enable gating, and configuration churn on steady pins.

// File: rtl/gpio_irq_pkg.sv
package gpio_irq_pkg;

   // Register offsets; software decodes these, so they are fixed.
   localparam int unsigned OFS_LEVEL  = 32'h404;
   localparam int unsigned OFS_ANY    = 32'h408;
   localparam int unsigned OFS_POL    = 32'h40C;
   localparam int unsigned OFS_ENABLE = 32'h410;
   localparam int unsigned OFS_RAW    = 32'h414;
   localparam int unsigned OFS_MASKED = 32'h418;
   localparam int unsigned OFS_ACK    = 32'h41C;

   // Minimum address width that reaches the highest offset.
   localparam int unsigned MIN_ADDR_W = 11;

   // Per-pin trigger setting.
   typedef struct packed {
      logic level;        // 1: level sensitive, 0: edge sensitive
      logic any_edge;     // edge mode: both transitions fire
      logic active_high;  // rising / high when 1, falling / low when 0
   } trig_cfg_t;

endpackage

// File: rtl/gpio_irq_cfg.sv
module gpio_irq_cfg
   import gpio_irq_pkg::*;
#(
   parameter int NPINS  = 8,
   parameter int ADDR_W = 12
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              reg_wr,
   input  logic [ADDR_W-1:0] reg_addr,
   input  logic [NPINS-1:0]  reg_wdata,
   output logic [NPINS-1:0]  level_q,
   output logic [NPINS-1:0]  any_q,
   output logic [NPINS-1:0]  pol_q,
   output logic [NPINS-1:0]  enable_q,
   output logic [NPINS-1:0]  ack_stb
);

   logic hit_level, hit_any, hit_pol, hit_enable, hit_ack;

   always_comb begin
      hit_level  = reg_wr && (reg_addr == ADDR_W'(OFS_LEVEL));
      hit_any    = reg_wr && (reg_addr == ADDR_W'(OFS_ANY));
      hit_pol    = reg_wr && (reg_addr == ADDR_W'(OFS_POL));
      hit_enable = reg_wr && (reg_addr == ADDR_W'(OFS_ENABLE));
      hit_ack    = reg_wr && (reg_addr == ADDR_W'(OFS_ACK));
   end

   // The acknowledge is a one-cycle pulse; nothing is stored.
   assign ack_stb = hit_ack ? reg_wdata : '0;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         level_q  <= '0;
         any_q    <= '0;
         pol_q    <= '0;
         enable_q <= '0;
      end else begin
         if (hit_level)  level_q  <= reg_wdata;
         if (hit_any)    any_q    <= reg_wdata;
         if (hit_pol)    pol_q    <= reg_wdata;
         if (hit_enable) enable_q <= reg_wdata;
      end
   end

   // A write stores exactly the written word.
   assert_cfg_store_R2: assert property (@(posedge clk) disable iff (!rst_n)
      hit_enable |=> (enable_q == $past(reg_wdata)));

endmodule

// File: rtl/gpio_irq_pin.sv
module gpio_irq_pin
   import gpio_irq_pkg::*;
(
   input  logic      clk,
   input  logic      rst_n,
   input  logic      armed,
   input  logic      pin,
   input  trig_cfg_t cfg,
   input  logic      ack,
   output logic      raw
);

   logic prev_q;
   logic latch_q;
   logic rise, fall, edge_hit, level_true;

   always_comb begin
      // Compare only with the previous pin sample, so a change of
      // configuration on its own cannot produce an event.
      rise       = armed & pin & ~prev_q;
      fall       = armed & ~pin & prev_q;
      if (cfg.any_edge)
         edge_hit = rise | fall;
      else
         edge_hit = cfg.active_high ? rise : fall;
      level_true = cfg.active_high ? pin : ~pin;
      raw        = cfg.level ? level_true : latch_q;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         prev_q  <= 1'b0;
         latch_q <= 1'b0;
      end else begin
         prev_q  <= pin;
         // A new edge wins over a simultaneous acknowledge.
         latch_q <= (latch_q & ~ack) | (edge_hit & ~cfg.level);
      end
   end

   // An edge latch can only rise after the pin changed.
   assert_edge_needs_toggle_R12: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(latch_q) |-> ($past(pin) != $past(prev_q)));

   // An acknowledge with no competing edge drops the latch.
   assert_ack_clears_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (ack && !edge_hit) |=> !latch_q);

   // An edge racing the acknowledge is kept.
   assert_ack_race_keeps_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (ack && edge_hit && !cfg.level) |=> latch_q);

   // Level mode follows the pin in the polarity chosen.
   assert_level_follows_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (cfg.level && cfg.active_high && pin) |-> raw);

   // Acknowledge cannot remove a level that holds.
   assert_level_ack_ignored_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (cfg.level && ack && !cfg.active_high && !pin) |-> raw);

endmodule

// File: rtl/gpio_irq_unit.sv
module gpio_irq_unit
   import gpio_irq_pkg::*;
#(
   parameter int NPINS  = 8,
   parameter int ADDR_W = 12
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [NPINS-1:0]  pin_in,
   input  logic              reg_wr,
   input  logic [ADDR_W-1:0] reg_addr,
   input  logic [NPINS-1:0]  reg_wdata,
   output logic [NPINS-1:0]  reg_rdata,
   output logic              irq_out
);

   if (NPINS < 1 || NPINS > 32) begin : g_bad_npins
      $error("gpio_irq_unit: NPINS must be 1..32");
   end
   if (ADDR_W < MIN_ADDR_W) begin : g_bad_addr
      $error("gpio_irq_unit: ADDR_W too small for the register offsets");
   end

   logic [NPINS-1:0] level_q, any_q, pol_q, enable_q, ack_stb;
   logic [NPINS-1:0] raw_st, masked_st;
   logic             armed_q;

   gpio_irq_cfg #(.NPINS(NPINS), .ADDR_W(ADDR_W)) u_cfg (
      .clk       (clk),
      .rst_n     (rst_n),
      .reg_wr    (reg_wr),
      .reg_addr  (reg_addr),
      .reg_wdata (reg_wdata),
      .level_q   (level_q),
      .any_q     (any_q),
      .pol_q     (pol_q),
      .enable_q  (enable_q),
      .ack_stb   (ack_stb)
   );

   // One cycle after reset the previous-sample registers hold real data.
   always_ff @(posedge clk) begin
      if (!rst_n) armed_q <= 1'b0;
      else        armed_q <= 1'b1;
   end

   for (genvar i = 0; i < NPINS; i++) begin : g_pin
      trig_cfg_t pin_cfg;
      assign pin_cfg = '{level: level_q[i], any_edge: any_q[i], active_high: pol_q[i]};
      gpio_irq_pin u_pin (
         .clk   (clk),
         .rst_n (rst_n),
         .armed (armed_q),
         .pin   (pin_in[i]),
         .cfg   (pin_cfg),
         .ack   (ack_stb[i]),
         .raw   (raw_st[i])
      );
   end

   assign masked_st = raw_st & enable_q;
   assign irq_out   = |masked_st;

   always_comb begin
      reg_rdata = '0;
      if      (reg_addr == ADDR_W'(OFS_LEVEL))  reg_rdata = level_q;
      else if (reg_addr == ADDR_W'(OFS_ANY))    reg_rdata = any_q;
      else if (reg_addr == ADDR_W'(OFS_POL))    reg_rdata = pol_q;
      else if (reg_addr == ADDR_W'(OFS_ENABLE)) reg_rdata = enable_q;
      else if (reg_addr == ADDR_W'(OFS_RAW))    reg_rdata = raw_st;
      else if (reg_addr == ADDR_W'(OFS_MASKED)) reg_rdata = masked_st;
   end

   // With every pin disabled the line stays quiet.
   assert_irq_gated_R11: assert property (@(posedge clk) disable iff (!rst_n)
      (enable_q == '0) |-> !irq_out);

   // Masked status never shows a bit the raw status lacks.
   assert_masked_subset_R10: assert property (@(posedge clk) disable iff (!rst_n)
      ((masked_st & ~raw_st) == '0));

endmodule

// File: tb/gpio_irq_unit_test.sv
module gpio_irq_unit_test;
   localparam int CLK_PERIOD = 10;
   localparam int NP = 8;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic [NP-1:0] pin_in = '0;
   logic          reg_wr = 1'b0;
   logic [11:0]   reg_addr = '0;
   logic [NP-1:0] reg_wdata = '0;
   logic [NP-1:0] reg_rdata;
   logic          irq_out;

   int checks = 0;
   int fails  = 0;
   bit done   = 1'b0;

   gpio_irq_unit #(.NPINS(NP), .ADDR_W(12)) uut (
      .clk(clk), .rst_n(rst_n), .pin_in(pin_in), .reg_wr(reg_wr),
      .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
      .irq_out(irq_out)
   );

   always #(CLK_PERIOD/2) clk = ~clk;

   task automatic chk(input string req, input string what,
                      input logic [31:0] got, input logic [31:0] exp);
      checks++;
      if (got !== exp) begin
         fails++;
         $display("FAIL %s %s: actual %h expected %h", req, what, got, exp);
      end
   endtask

   task automatic wr(input logic [11:0] a, input logic [NP-1:0] d);
      @(negedge clk);
      reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
      @(negedge clk);
      reg_wr = 1'b0; reg_wdata = '0;
   endtask

   task automatic rd(input logic [11:0] a, output logic [NP-1:0] d);
      reg_addr = a;
      #1;
      d = reg_rdata;
   endtask

   task automatic set_pins(input logic [NP-1:0] v);
      @(negedge clk);
      pin_in = v;
      @(negedge clk);
   endtask

   task automatic do_reset(input logic [NP-1:0] pins);
      @(negedge clk);
      rst_n = 1'b0; pin_in = pins;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      repeat (3) @(negedge clk);
   endtask

   initial begin
      #(CLK_PERIOD * 100000);
      if (!done) begin
         fails++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
         $finish;
      end
   end

   initial begin
      logic [NP-1:0] d;
      do_reset('0);

      // R1 reset state
      rd(12'h404, d); chk("R1", "level reg", d, 0);
      rd(12'h408, d); chk("R1", "any reg", d, 0);
      rd(12'h40C, d); chk("R1", "pol reg", d, 0);
      rd(12'h410, d); chk("R1", "enable reg", d, 0);
      rd(12'h414, d); chk("R1", "raw", d, 0);
      rd(12'h418, d); chk("R1", "masked", d, 0);
      chk("R1", "irq", irq_out, 0);

      // R2 readback at each offset
      wr(12'h404, 8'hA5); wr(12'h408, 8'h3C); wr(12'h40C, 8'h81); wr(12'h410, 8'h5A);
      rd(12'h404, d); chk("R2", "level reg", d, 8'hA5);
      rd(12'h408, d); chk("R2", "any reg", d, 8'h3C);
      rd(12'h40C, d); chk("R2", "pol reg", d, 8'h81);
      rd(12'h410, d); chk("R2", "enable reg", d, 8'h5A);

      // Sweep: every pin, every trigger setting (R3 R4 R5 R6 R10 R11)
      for (int p = 0; p < NP; p++) begin
         for (int m = 0; m < 6; m++) begin
            bit s, b, e, rise_en, fall_en, lat, exp_bit, cur;
            string req;
            s = (m >= 4);
            b = (m == 2 || m == 3);
            e = (m == 0 || m == 3 || m == 4);
            rise_en = (m == 0 || m == 2 || m == 3);
            fall_en = (m == 1 || m == 2 || m == 3);
            req = (m == 0) ? "R3" : (m == 1) ? "R4" : (m <= 3) ? "R5" : "R6";
            set_pins('0);
            wr(12'h404, NP'(s) << p);
            wr(12'h408, NP'(b) << p);
            wr(12'h40C, NP'(e) << p);
            wr(12'h410, NP'(1) << p);
            wr(12'h41C, '1);
            lat = 1'b0; cur = 1'b0;
            for (int st = 0; st < 4; st++) begin
               bit nxt;
               nxt = (st == 0) ? 1'b0 : st[0];
               if (st != 0) begin
                  set_pins(NP'(nxt) << p);
                  if (!cur && nxt && rise_en) lat = 1'b1;
                  if (cur && !nxt && fall_en) lat = 1'b1;
               end
               cur = nxt;
               exp_bit = s ? (e ? cur : !cur) : lat;
               rd(12'h414, d); chk(req, "raw status", d, NP'(exp_bit) << p);
               rd(12'h418, d); chk("R10", "masked status", d, NP'(exp_bit) << p);
               chk("R11", "irq line", irq_out, exp_bit);
            end
         end
      end

      // R7 partial acknowledge, zero bits untouched
      set_pins('0);
      wr(12'h404, '0); wr(12'h408, '1); wr(12'h40C, '0); wr(12'h410, '1);
      wr(12'h41C, '1);
      set_pins(8'h0F);
      rd(12'h414, d); chk("R7", "latched", d, 8'h0F);
      wr(12'h41C, 8'h05);
      rd(12'h414, d); chk("R7", "after partial ack", d, 8'h0A);
      wr(12'h41C, 8'h00);
      rd(12'h414, d); chk("R7", "zero ack no effect", d, 8'h0A);

      // R10/R11 enable gating with raw set
      wr(12'h410, 8'h00);
      rd(12'h418, d); chk("R10", "masked off", d, 8'h00);
      chk("R11", "irq off when disabled", irq_out, 0);
      wr(12'h410, 8'h08);
      rd(12'h418, d); chk("R10", "masked one", d, 8'h08);
      chk("R11", "irq on", irq_out, 1);

      // R9 acknowledge racing an edge on pin 0
      wr(12'h41C, '1);
      set_pins(8'h00);
      wr(12'h41C, '1);
      @(negedge clk);
      pin_in = 8'h01; reg_wr = 1'b1; reg_addr = 12'h41C; reg_wdata = 8'h01;
      @(negedge clk);
      reg_wr = 1'b0; reg_wdata = '0;
      rd(12'h414, d); chk("R9", "edge survives ack", d, 8'h01);
      wr(12'h41C, 8'h01);
      rd(12'h414, d); chk("R9", "later ack clears", d, 8'h00);

      // R8 acknowledge against a holding level
      wr(12'h404, 8'h10); wr(12'h40C, 8'h10); wr(12'h410, 8'h10);
      set_pins(8'h10);
      wr(12'h41C, 8'h10);
      rd(12'h414, d); chk("R8", "level kept", d & 8'h10, 8'h10);
      chk("R8", "irq kept", irq_out, 1);

      // R12 configuration churn on steady pins
      wr(12'h404, '0); wr(12'h408, '0); wr(12'h40C, '0);
      set_pins(8'h0F);
      wr(12'h41C, '1);
      wr(12'h40C, '1); wr(12'h408, '1); wr(12'h404, '1); wr(12'h404, '0);
      wr(12'h408, '0); wr(12'h40C, '0); wr(12'h408, '1);
      rd(12'h414, d); chk("R12", "no edge from config", d, 8'h00);

      // R12 first sample after reset is not an edge
      do_reset(8'hFF);
      wr(12'h408, '1); wr(12'h410, '1);
      rd(12'h414, d); chk("R12", "no edge after reset", d, 8'h00);
      chk("R12", "irq quiet after reset", irq_out, 0);

      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end
endmodule